// File: doc/BRIEF.md
# Multithreaded Commit Thread Selector

This block decides which of N hardware threads is allowed to retire its oldest instruction next. Each thread reports its commit-stage status, whether its reorder buffer is empty, whether the instruction at the buffer head is ready, and that head instruction's sequence number. A static policy input picks the arbitration rule. The result is a thread index with a valid bit.

Two rules are built. The first is a rotating rule that keeps an ordered priority list of thread indices. It grants the first qualifying thread in the list. When the commit logic takes that grant, only the winner moves to the back of the list. The second rule is age based: it grants the qualifying thread whose head has the smallest sequence number. A third policy code, the aggressive one, uses the age-based rule. The output is combinational on the current inputs. The commit loop can therefore ask again after each accepted grant, once per clock.

When the block is built for one thread, arbitration is skipped. The thread is returned whenever its status is eligible.

Top module: `smt_commit_sel`

## Requirements
- R1: status_i holds a 3-bit code per thread at bits [3*t+2:3*t]: 0 idle, 1 running, 2 buffer squashing, 3 trap pending, 4 fetch-trap pending, 5 to 7 unused. Only codes 0, 1 and 4 are eligible.
- R2: With N > 1, a thread qualifies only if it is eligible, its rob_empty_i bit is 0 and its head_ready_i bit is 1. A thread that is not eligible is never selected, even when its head is ready.
- R3: After reset the priority list holds thread indices 0 to N-1 in ascending order, so the first rotating grants with every thread qualifying come out 0, 1, 2, ...
- R4: Under policy_i = 0 (rotating), the output is the first qualifying thread in priority-list order.
- R5: When accept_i is 1 in a cycle where policy_i = 0 and sel_valid_o = 1, the granted thread moves to the tail of the list at the clock edge, and the other entries keep their relative order. In every other cycle, and under every other policy, the list is unchanged.
- R6: Under policy_i = 1 (oldest), the output is the qualifying thread with the smallest head_seq_i, compared unsigned. Sequence numbers sit at bits [SEQ_W*t +: SEQ_W]. On equal numbers the lower thread index wins.
- R7: policy_i = 2 (aggressive) and policy_i = 3 select exactly as policy_i = 1 does.
- R8: If no thread qualifies, sel_valid_o is 0 and sel_tid_o is 0.
- R9: With N = 1, sel_valid_o equals the eligibility of the thread's status, whatever its head readiness and buffer emptiness. sel_tid_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| policy_i | input | 2 | Arbitration policy: 0 rotating, 1 oldest, 2 and 3 aggressive |
| status_i | input | 3*N | Per-thread commit status codes |
| rob_empty_i | input | N | Per-thread reorder buffer empty |
| head_ready_i | input | N | Per-thread head instruction ready to commit |
| head_seq_i | input | SEQ_W*N | Per-thread head sequence number |
| accept_i | input | 1 | The current grant is consumed this cycle |
| sel_valid_o | output | 1 | A thread is selected |
| sel_tid_o | output | TID_W | Selected thread index |

## Verification
The rotating rule is checked against a queue model over long accepted and unaccepted runs. A design that rotated the whole list would grant out of order once a non-first entry wins. A design that updated the list without accept_i would skip threads.

The age rule is driven with narrow sequence numbers so that ties are frequent. A wrong tie-break would return the higher index. Threads with a ready head but status codes 2, 3 or 5 to 7 are offered often, so a decode that admitted them would grant them. A single-thread instance is driven with its head not ready, where a design that still checked readiness would drop the grant.

// File: rtl/smt_sel_pkg.sv
package smt_sel_pkg;
  localparam int unsigned ST_W = 3;

  typedef enum logic [ST_W-1:0] {
    ST_IDLE       = 3'd0,
    ST_RUNNING    = 3'd1,
    ST_SQUASHING  = 3'd2,
    ST_TRAP_PEND  = 3'd3,
    ST_FTRAP_PEND = 3'd4
  } thr_status_e;

  typedef enum logic [1:0] {
    POL_ROTATE = 2'd0,
    POL_OLDEST = 2'd1,
    POL_AGGR   = 2'd2,
    POL_RSVD   = 2'd3
  } sel_policy_e;

  function automatic logic status_eligible(logic [ST_W-1:0] st);
    return (st == ST_IDLE) || (st == ST_RUNNING) || (st == ST_FTRAP_PEND);
  endfunction
endpackage

// File: rtl/smt_sel_elig.sv
module smt_sel_elig
  import smt_sel_pkg::*;
#(
  parameter int unsigned N = 4
) (
  input  logic [ST_W*N-1:0] status_i,
  output logic [N-1:0]      elig_o
);
  for (genvar t = 0; t < N; t++) begin : g_thr
    assign elig_o[t] = status_eligible(status_i[ST_W*t +: ST_W]);
  end
endmodule

// File: rtl/smt_sel_rotate.sv
module smt_sel_rotate #(
  parameter int unsigned N     = 4,
  parameter int unsigned TID_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N-1:0]       qual_i,
  input  logic               take_i,
  output logic               found_o,
  output logic [TID_W-1:0]   tid_o,
  output logic [N*TID_W-1:0] list_o
);
  logic [TID_W-1:0] lst_q [N];
  logic [TID_W-1:0] lst_n [N];
  logic [TID_W-1:0] pos;

  // first qualifying entry in list order
  always_comb begin
    found_o = 1'b0;
    pos     = '0;
    for (int i = 0; i < N; i++) begin
      if (!found_o && qual_i[lst_q[i]]) begin
        found_o = 1'b1;
        pos     = TID_W'(i);
      end
    end
    tid_o = found_o ? lst_q[pos] : '0;
  end

  // winner goes to tail, entries behind it close the gap
  always_comb begin
    for (int i = 0; i < N; i++) lst_n[i] = lst_q[i];
    if (take_i) begin
      for (int i = 0; i < N - 1; i++) begin
        if (i >= int'(pos)) lst_n[i] = lst_q[i+1];
      end
      lst_n[N-1] = lst_q[pos];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) lst_q[i] <= TID_W'(i);
    end else begin
      for (int i = 0; i < N; i++) lst_q[i] <= lst_n[i];
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_flat
    assign list_o[TID_W*i +: TID_W] = lst_q[i];
  end
endmodule

// File: rtl/smt_sel_oldest.sv
module smt_sel_oldest #(
  parameter int unsigned N     = 4,
  parameter int unsigned SEQ_W = 8,
  parameter int unsigned TID_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]       qual_i,
  input  logic [SEQ_W*N-1:0] seq_i,
  output logic               found_o,
  output logic [TID_W-1:0]   tid_o
);
  logic [SEQ_W-1:0] best;

  // strict less-than keeps the lower index on ties
  always_comb begin
    found_o = 1'b0;
    tid_o   = '0;
    best    = '0;
    for (int i = 0; i < N; i++) begin
      if (qual_i[i] && (!found_o || (seq_i[SEQ_W*i +: SEQ_W] < best))) begin
        found_o = 1'b1;
        tid_o   = TID_W'(i);
        best    = seq_i[SEQ_W*i +: SEQ_W];
      end
    end
  end
endmodule

// File: rtl/smt_commit_sel.sv
module smt_commit_sel
  import smt_sel_pkg::*;
#(
  parameter int unsigned N     = 4,
  parameter int unsigned SEQ_W = 8,
  localparam int unsigned TID_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         policy_i,
  input  logic [ST_W*N-1:0]  status_i,
  input  logic [N-1:0]       rob_empty_i,
  input  logic [N-1:0]       head_ready_i,
  input  logic [SEQ_W*N-1:0] head_seq_i,
  input  logic               accept_i,
  output logic               sel_valid_o,
  output logic [TID_W-1:0]   sel_tid_o
);
  logic [N-1:0]       elig;
  logic [N*TID_W-1:0] prio_flat;

  smt_sel_elig #(.N(N)) u_elig (
    .status_i (status_i),
    .elig_o   (elig)
  );

  if (N == 1) begin : g_single
    assign sel_valid_o = elig[0];
    assign sel_tid_o   = '0;
    assign prio_flat   = '0;
  end else begin : g_multi
    logic [N-1:0]     qual;
    logic             rot_found, old_found, use_rot;
    logic [TID_W-1:0] rot_tid, old_tid;

    assign qual    = elig & ~rob_empty_i & head_ready_i;
    assign use_rot = (policy_i == POL_ROTATE);

    smt_sel_rotate #(.N(N), .TID_W(TID_W)) u_rot (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .qual_i  (qual),
      .take_i  (accept_i && use_rot && rot_found),
      .found_o (rot_found),
      .tid_o   (rot_tid),
      .list_o  (prio_flat)
    );

    smt_sel_oldest #(.N(N), .SEQ_W(SEQ_W), .TID_W(TID_W)) u_old (
      .qual_i  (qual),
      .seq_i   (head_seq_i),
      .found_o (old_found),
      .tid_o   (old_tid)
    );

    assign sel_valid_o = use_rot ? rot_found : old_found;
    assign sel_tid_o   = use_rot ? rot_tid : old_tid;
  end
endmodule

// File: rtl/smt_commit_sel_chk.sv
module smt_commit_sel_chk
  import smt_sel_pkg::*;
#(
  parameter int unsigned N     = 4,
  parameter int unsigned SEQ_W = 8,
  parameter int unsigned TID_W = (N > 1) ? $clog2(N) : 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [1:0]         policy_i,
  input logic [ST_W*N-1:0]  status_i,
  input logic [N-1:0]       rob_empty_i,
  input logic [N-1:0]       head_ready_i,
  input logic [SEQ_W*N-1:0] head_seq_i,
  input logic               accept_i,
  input logic               sel_valid_o,
  input logic [TID_W-1:0]   sel_tid_o,
  input logic [N*TID_W-1:0] prio_flat
);
  logic [N-1:0] q;
  logic         sel_elig, sel_qual, older_exists, earlier_exists, seen_sel;
  logic [N-1:0] in_list;

  always_comb begin
    for (int t = 0; t < N; t++)
      q[t] = status_eligible(status_i[ST_W*t +: ST_W]) && !rob_empty_i[t] && head_ready_i[t];
    sel_elig = status_eligible(status_i[ST_W*int'(sel_tid_o) +: ST_W]);
    sel_qual = q[sel_tid_o];
    older_exists = 1'b0;
    for (int t = 0; t < N; t++) begin
      if (q[t] && ((head_seq_i[SEQ_W*t +: SEQ_W] < head_seq_i[SEQ_W*int'(sel_tid_o) +: SEQ_W]) ||
                   ((head_seq_i[SEQ_W*t +: SEQ_W] == head_seq_i[SEQ_W*int'(sel_tid_o) +: SEQ_W]) &&
                    (t < int'(sel_tid_o)))))
        older_exists = 1'b1;
    end
    earlier_exists = 1'b0;
    seen_sel       = 1'b0;
    in_list        = '0;
    for (int i = 0; i < N; i++) begin
      in_list[prio_flat[TID_W*i +: TID_W]] = 1'b1;
      if (prio_flat[TID_W*i +: TID_W] == sel_tid_o) seen_sel = 1'b1;
      else if (!seen_sel && q[prio_flat[TID_W*i +: TID_W]]) earlier_exists = 1'b1;
    end
  end

  AST_SEL_ELIGIBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_valid_o |-> sel_elig); // R1

  if (N > 1) begin : g_multi_chk
    AST_SEL_QUALIFIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sel_valid_o |-> sel_qual); // R2
    AST_NONE_INVALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (q == '0) |-> (!sel_valid_o && sel_tid_o == '0)); // R8
    AST_ANY_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (q != '0) |-> sel_valid_o); // R4
    AST_OLDEST_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (policy_i != 2'd0 && sel_valid_o) |-> !older_exists); // R6
    AST_ROTATE_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (policy_i == 2'd0 && sel_valid_o) |-> !earlier_exists); // R4
    AST_LIST_PERM: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(in_list) == N); // R5
    AST_LIST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(accept_i && sel_valid_o && policy_i == 2'd0) |=> $stable(prio_flat)); // R5
  end
endmodule

bind smt_commit_sel smt_commit_sel_chk #(.N(N), .SEQ_W(SEQ_W), .TID_W(TID_W)) u_chk (.*);

// File: tb/smt_commit_sel_tb.sv
module smt_commit_sel_tb;
  localparam int N = 4;
  localparam int SW = 4;
  localparam int TW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [1:0]      policy;
  logic [3*N-1:0]  status;
  logic [N-1:0]    empty, ready;
  logic [SW*N-1:0] seq;
  logic            accept;
  logic            vld;
  logic [TW-1:0]   tid;

  logic [2:0] s1_status;
  logic       s1_empty, s1_ready, s1_vld;
  logic       s1_tid;

  smt_commit_sel #(.N(N), .SEQ_W(SW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .policy_i(policy), .status_i(status),
    .rob_empty_i(empty), .head_ready_i(ready), .head_seq_i(seq),
    .accept_i(accept), .sel_valid_o(vld), .sel_tid_o(tid));

  smt_commit_sel #(.N(1), .SEQ_W(SW)) u_dut_single (
    .clk_i(clk), .rst_ni(rst_n), .policy_i(policy), .status_i(s1_status),
    .rob_empty_i(s1_empty), .head_ready_i(s1_ready), .head_seq_i(seq[SW-1:0]),
    .accept_i(accept), .sel_valid_o(s1_vld), .sel_tid_o(s1_tid));

  int total = 0;
  int bad = 0;
  bit done = 0;
  int plist[$];

  function automatic bit elig_code(int c);
    return c == 0 || c == 1 || c == 4;
  endfunction

  function automatic bit qualif(int t);
    return elig_code(int'(status[3*t +: 3])) && !empty[t] && ready[t];
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // compute expectation, compare, then advance the model for the coming edge
  task automatic step(string req);
    int ev, et, best;
    ev = 0; et = 0; best = 0;
    #1;
    if (policy == 2'd0) begin
      foreach (plist[i]) if (ev == 0 && qualif(plist[i])) begin ev = 1; et = plist[i]; end
    end else begin
      for (int t = 0; t < N; t++)
        if (qualif(t) && (ev == 0 || int'(seq[SW*t +: SW]) < best)) begin
          ev = 1; et = t; best = int'(seq[SW*t +: SW]);
        end
    end
    chk(req, int'(vld), ev);
    chk(req, int'(tid), et);
    chk("R9", int'(s1_vld), int'(elig_code(int'(s1_status))));
    chk("R9", int'(s1_tid), 0);
    if (accept && ev == 1 && policy == 2'd0) begin
      foreach (plist[i]) if (plist[i] == et) begin plist.delete(i); break; end
      plist.push_back(et);
    end
    @(negedge clk);
  endtask

  task automatic set_all(int st, bit e, bit r);
    for (int t = 0; t < N; t++) begin
      status[3*t +: 3] = 3'(st); empty[t] = e; ready[t] = r;
    end
  endtask

  initial begin
    policy = 2'd0; status = '0; empty = '0; ready = '0; seq = '0; accept = 1'b0;
    s1_status = 3'd0; s1_empty = 1'b1; s1_ready = 1'b0;
    for (int t = 0; t < N; t++) plist.push_back(t);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: ascending order from reset, every thread qualifies
    set_all(1, 0, 1); accept = 1'b1;
    for (int k = 0; k < 5; k++) step("R3");

    // R5: only thread 2 qualifies, then all; 2 must be last
    set_all(1, 0, 1); status[3*0 +: 3] = 3'd2; status[3*1 +: 3] = 3'd3; status[3*3 +: 3] = 3'd5;
    step("R5");
    set_all(0, 0, 1);
    for (int k = 0; k < 4; k++) step("R4");

    // R5: no accept, list holds
    accept = 1'b0;
    for (int k = 0; k < 3; k++) step("R5");
    accept = 1'b1;

    // R2: ineligible statuses with ready heads, and an empty buffer
    set_all(3, 0, 1); status[3*2 +: 3] = 3'd4; empty[2] = 1'b1;
    step("R2");
    step("R8");

    // R6: tie between 1 and 3, lower index wins
    policy = 2'd1; set_all(1, 0, 1); status[3*0 +: 3] = 3'd2;
    seq = '0; seq[SW*1 +: SW] = 4'd5; seq[SW*2 +: SW] = 4'd9; seq[SW*3 +: SW] = 4'd5;
    step("R6");
    policy = 2'd2; step("R7");
    policy = 2'd3; step("R7");
    set_all(7, 0, 1); step("R8");

    // R9: single thread granted with head not ready
    s1_status = 3'd4; s1_empty = 1'b1; s1_ready = 1'b0;
    step("R9");
    s1_status = 3'd2; step("R9");

    // randomized sweeps per policy
    for (int p = 0; p < 4; p++) begin
      policy = 2'(p);
      for (int k = 0; k < 600; k++) begin
        for (int t = 0; t < N; t++) begin
          status[3*t +: 3] = ($urandom_range(0, 3) == 0) ? 3'($urandom_range(0, 7)) : 3'($urandom_range(0, 1));
          empty[t] = ($urandom_range(0, 4) == 0);
          ready[t] = ($urandom_range(0, 3) != 0);
          seq[SW*t +: SW] = SW'($urandom_range(0, 7));
        end
        accept = ($urandom_range(0, 2) != 0);
        s1_status = 3'($urandom_range(0, 7));
        s1_empty = 1'($urandom_range(0, 1));
        s1_ready = 1'($urandom_range(0, 1));
        step(p == 0 ? "R4" : (p == 1 ? "R6" : "R7"));
      end
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      repeat (20000) @(posedge clk);
    join_any
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule